// File: doc/BRIEF.md
# Comparator edge interrupt controller

This block is the digital control logic that sits around an analog comparator inside a microcontroller. The comparator's raw result arrives as an asynchronous bit. The block synchronizes it and publishes it as an unlatched live status bit. It also passes it through a stability filter, and an edge detector watches the filtered level for a transition in the direction that software selects.

A qualifying transition sets a sticky flag. The flag stays set until software clears it. While the interrupt enable is on, the flag produces a registered interrupt request.

Software drives four control bits through a single write port. Those bits decide three things:
- whether the comparator owns its two input pins;
- whether the result drives the output pin or leaves it as general-purpose I/O;
- the edge direction and the interrupt enable.

A separate strobe clears the flag.

Top module: `cmp_edge_irq`

## Requirements
- R1: After reset all control bits are 0, the flag and the interrupt request are 0, and all pin-ownership outputs are 0, so the pins stay general-purpose I/O.
- R2: A write with `ctl_we` high loads `ctl_wdata` on the next clock edge. Bit 0 is the comparator enable, bit 1 is the output enable, bit 2 is the edge select and bit 3 is the interrupt enable. `cmp_in_conn` equals the enable. `cmp_out_drive` equals enable AND output enable. `cmp_out_val` carries the live result while the pin is driven and is 0 otherwise.
- R3: While the comparator is enabled, `cmp_live` equals `cmp_raw` delayed by two clock edges, with no latching. While the comparator is disabled, `cmp_live` is 0.
- R4: The filtered level takes a new value only after the synchronized input has differed from it on FILT_CYCLES consecutive clock edges. A pulse shorter than FILT_CYCLES cycles never sets the flag. A pulse of exactly FILT_CYCLES cycles is accepted.
- R5: With edge select 0, a high-to-low filtered transition sets the flag. With edge select 1, a low-to-high transition sets it. The flag is first high after the (FILT_CYCLES+3)th clock edge following the change on `cmp_raw`.
- R6: Once set, the flag stays set through any later comparator activity until a cycle with `flag_clr` high clears it.
- R7: If a clear and a flag-setting edge fall in the same cycle, the flag ends up set.
- R8: Setting the enable, or changing the edge select, never sets the flag by itself, whatever level the comparator input holds.
- R9: While the comparator is disabled, the flag cannot become set and `cmp_irq` is 0.
- R10: `cmp_irq` is a register loaded with flag AND interrupt enable AND comparator enable. It follows the flag one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_raw | input | 1 | Asynchronous comparator result |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control value: {irq enable, edge select, output enable, enable} |
| flag_clr | input | 1 | Clears the sticky flag |
| cmp_in_conn | output | 1 | Input pins are connected to the comparator |
| cmp_out_drive | output | 1 | Output pin is owned by the comparator |
| cmp_out_val | output | 1 | Value to drive on the output pin |
| cmp_live | output | 1 | Unlatched synchronized comparator result |
| cmp_flag | output | 1 | Sticky edge flag |
| cmp_irq | output | 1 | Registered interrupt request |

## Verification
The bench applies pulses of exactly FILT_CYCLES-1 and FILT_CYCLES cycles. A filter that is off by one either accepts a glitch or drops a real edge. It checks the flag and the request on their exact edges, which exposes an extra or a missing pipeline stage. It lines up a clear strobe with the cycle in which the flag gets set, which catches a design that lets the clear win and loses the event. It also enables the comparator while its input is already high with rising-edge select, and flips the edge select on a steady input. A design that does not reload the previous level in those cases raises a spurious flag.

// File: rtl/cmp_edge_irq.sv
module cmp_edge_irq #(
  parameter int FILT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_raw,
  input  logic       ctl_we,
  input  logic [3:0] ctl_wdata,
  input  logic       flag_clr,
  output logic       cmp_in_conn,
  output logic       cmp_out_drive,
  output logic       cmp_out_val,
  output logic       cmp_live,
  output logic       cmp_flag,
  output logic       cmp_irq
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic en_q, oen_q, sel_q, ien_q;
  logic sync_q1, sync_q2;
  logic filt_q, prev_q;
  logic [CW-1:0] stab_cnt;
  logic flag_q, irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; oen_q <= 1'b0; sel_q <= 1'b0; ien_q <= 1'b0;
    end else if (ctl_we) begin
      en_q  <= ctl_wdata[0];
      oen_q <= ctl_wdata[1];
      sel_q <= ctl_wdata[2];
      ien_q <= ctl_wdata[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= cmp_raw;
      sync_q2 <= sync_q1;
    end
  end

  wire en_rise  = ctl_we & ctl_wdata[0] & ~en_q;
  wire sel_chg  = ctl_we & (ctl_wdata[2] != sel_q);
  wire quiet    = en_rise | sel_chg;
  wire edge_hit = en_q & (sel_q ? (filt_q & ~prev_q) : (~filt_q & prev_q));
  wire flag_set = edge_hit & ~quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_q   <= 1'b0;
      prev_q   <= 1'b0;
      stab_cnt <= '0;
    end else if (!en_q) begin
      filt_q   <= en_rise & sync_q2;
      prev_q   <= en_rise & sync_q2;
      stab_cnt <= '0;
    end else begin
      prev_q <= filt_q;
      if (sync_q2 == filt_q) begin
        stab_cnt <= '0;
      end else if (stab_cnt == LAST) begin
        filt_q   <= sync_q2;
        stab_cnt <= '0;
      end else begin
        stab_cnt <= stab_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_set | (flag_q & ~flag_clr);
      irq_q  <= flag_q & ien_q & en_q;
    end
  end

  assign cmp_in_conn   = en_q;
  assign cmp_out_drive = en_q & oen_q;
  assign cmp_live      = en_q & sync_q2;
  assign cmp_out_val   = cmp_out_drive & sync_q2;
  assign cmp_flag      = flag_q;
  assign cmp_irq       = irq_q;
endmodule

module cmp_edge_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic en_q,
  input logic ien_q,
  input logic sync_q2,
  input logic filt_q,
  input logic flag_set,
  input logic flag_clr,
  input logic cmp_flag,
  input logic cmp_irq
);
  p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cmp_irq == ($past(cmp_flag) & $past(ien_q) & $past(en_q)));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_flag && !flag_clr |=> cmp_flag);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> cmp_flag);

  p_no_irq_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !cmp_irq);

  p_no_set_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !cmp_flag |=> !cmp_flag);

  p_filt_from_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && $past(en_q) && filt_q != $past(filt_q) |-> filt_q == $past(sync_q2));
endmodule

bind cmp_edge_irq cmp_edge_irq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .ien_q(ien_q), .sync_q2(sync_q2),
  .filt_q(filt_q), .flag_set(flag_set), .flag_clr(flag_clr),
  .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
);

// File: tb/cmp_edge_irq_tb.sv
module cmp_edge_irq_tb_top;
  localparam int F = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_raw = 1'b0;
  logic ctl_we = 1'b0;
  logic [3:0] ctl_wdata = 4'h0;
  logic flag_clr = 1'b0;
  logic cmp_in_conn, cmp_out_drive, cmp_out_val, cmp_live, cmp_flag, cmp_irq;

  int vectors = 0;
  int miscompares = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  cmp_edge_irq #(.FILT_CYCLES(F)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .flag_clr(flag_clr), .cmp_in_conn(cmp_in_conn),
    .cmp_out_drive(cmp_out_drive), .cmp_out_val(cmp_out_val),
    .cmp_live(cmp_live), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
  );

  function automatic logic exp_step(logic from_lvl, logic to_lvl, logic sel);
    return sel ? (!from_lvl && to_lvl) : (from_lvl && !to_lvl);
  endfunction

  function automatic logic exp_pulse(int len);
    return len >= F;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic ien, logic sel, logic oen, logic en);
    ctl_we = 1'b1; ctl_wdata = {ien, sel, oen, en};
    step(1);
    ctl_we = 1'b0;
  endtask

  task automatic clr();
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7321));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 flag", cmp_flag, 1'b0);
    chk("R1 irq", cmp_irq, 1'b0);
    chk("R1 in_conn", cmp_in_conn, 1'b0);
    chk("R1 out_drive", cmp_out_drive, 1'b0);

    // R9 disabled: activity does nothing
    cmp_raw = 1'b1; step(2 * F + 6);
    cmp_raw = 1'b0; step(2 * F + 6);
    chk("R9 flag disabled", cmp_flag, 1'b0);
    chk("R9 irq disabled", cmp_irq, 1'b0);
    chk("R3 live disabled", cmp_live, 1'b0);

    // R8 enable with input already high, rising select
    cmp_raw = 1'b1; step(4);
    wr(1'b1, 1'b1, 1'b1, 1'b1);
    step(3 * F);
    chk("R8 enable no edge", cmp_flag, 1'b0);
    chk("R2 in_conn", cmp_in_conn, 1'b1);
    chk("R2 out_drive", cmp_out_drive, 1'b1);
    chk("R2 out_val", cmp_out_val, 1'b1);
    // R8 flip select on steady input
    wr(1'b1, 1'b0, 1'b1, 1'b1);
    step(3 * F);
    wr(1'b1, 1'b1, 1'b1, 1'b1);
    step(3 * F);
    chk("R8 select flip no edge", cmp_flag, 1'b0);

    // R3 live latency, R5 flag timing (falling, sel 0), R10 irq timing
    wr(1'b1, 1'b0, 1'b0, 1'b1);
    step(2);
    cmp_raw = 1'b0;
    step(1);
    chk("R3 live after one edge", cmp_live, 1'b1);
    step(1);
    chk("R3 live after two edges", cmp_live, 1'b0);
    chk("R2 out_val not driven", cmp_out_val, 1'b0);
    step(F);
    chk("R5 flag not yet", cmp_flag, 1'b0);
    step(1);
    chk("R5 flag on time", cmp_flag, 1'b1);
    chk("R10 irq lags", cmp_irq, 1'b0);
    step(1);
    chk("R10 irq on time", cmp_irq, 1'b1);

    // R6 sticky across opposite edge
    cmp_raw = 1'b1; step(3 * F);
    chk("R6 flag sticky", cmp_flag, 1'b1);
    clr();
    chk("R6 flag cleared", cmp_flag, 1'b0);
    step(1);
    chk("R10 irq drops", cmp_irq, 1'b0);

    // R7 clear in the same cycle as a set
    cmp_raw = 1'b0;
    step(F + 2);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    chk("R7 set beats clear", cmp_flag, 1'b1);
    clr();

    // R4 boundary pulses
    for (int len = F - 1; len <= F; len++) begin
      clr();
      cmp_raw = 1'b1; step(len);
      cmp_raw = 1'b0; step(3 * F);
      chk("R4 pulse boundary", cmp_flag, exp_pulse(len));
    end

    // R5 R4 R10 R2 random
    for (int it = 0; it < 120; it++) begin
      logic sel = 1'($urandom_range(0, 1));
      logic ien = 1'($urandom_range(0, 1));
      logic oen = 1'($urandom_range(0, 1));
      logic old = cmp_raw;
      wr(ien, sel, oen, 1'b1);
      step(2 * F + 4);
      clr();
      step(2);
      if ($urandom_range(0, 2) == 0) begin
        int len = $urandom_range(1, 2 * F);
        cmp_raw = ~old; step(len);
        cmp_raw = old; step(3 * F);
        chk("R4 random pulse", cmp_flag, exp_pulse(len));
        chk("R10 random pulse irq", cmp_irq, exp_pulse(len) & ien);
      end else begin
        logic nxt = 1'($urandom_range(0, 1));
        cmp_raw = nxt; step(3 * F);
        chk("R5 random step", cmp_flag, exp_step(old, nxt, sel));
        chk("R10 random step irq", cmp_irq, exp_step(old, nxt, sel) & ien);
        chk("R3 random live", cmp_live, nxt);
        chk("R2 random out_val", cmp_out_val, oen & nxt);
      end
    end

    // R9 disable drops irq
    cmp_raw = 1'b1; step(3 * F);
    wr(1'b1, 1'b0, 1'b0, 1'b1);
    cmp_raw = 1'b0; step(3 * F);
    wr(1'b1, 1'b0, 1'b0, 1'b0);
    step(1);
    chk("R9 irq low when disabled", cmp_irq, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule